// File: doc/BRIEF.md
# Paged Window Register Bridge

This block lets a host reach a wide internal register space through a narrow 4 KB memory-mapped window. The internal space spans up to 32 devices, and each device has a 16-bit word address. The host first writes a page register that names the target device and the upper seven bits of the internal address. Each access to the lower half of the window then becomes one internal register transaction. The word offset inside the window supplies the low nine bits of that address.

The host side is a valid/ready request channel with a separate one-cycle read-response strobe. The internal side is a request held until acknowledged. It carries a word address, a device select, a direction flag and 16-bit write data. The bridge handles one transaction at a time. The page register keeps its value between accesses, so a run of accesses to the same page needs only one page write.

Top module: `paged_window_bridge`

## Requirements
- R1: After reset the page register is zero, `hostReqReady` is 1, and both `hostRspValid` and `intReqValid` are 0.
- R2: A host write to byte offset 0x800 loads the page register from `hostReqWdata[11:0]`. The device field is bits [11:7] and the page field is bits [6:0]. Bits [31:12] are ignored. `intDevSel` shows the new device field from the cycle after the write is accepted.
- R3: A host read of offset 0x800 returns the page register zero-extended to 32 bits. `hostRspValid` is high for exactly one cycle, the cycle after acceptance.
- R4: A host access to a byte offset below 0x800 is forwarded. `intAddr` is {page field, byte offset bits [10:2]} and `intDevSel` is the device field. Byte offset bits [1:0] are ignored.
- R5: `intReqValid` rises in the cycle after a forwarded access is accepted. It stays high until the cycle that `intAck` is sampled high. Address, select, direction and write data stay stable while it waits. `intWdata` is `hostReqWdata[15:0]`.
- R6: A forwarded read raises `hostRspValid` for one cycle, the cycle after the acknowledge. The response carries `intRdata` zero-extended to 32 bits.
- R7: A forwarded write produces no host response, and `hostReqReady` returns to 1 in the cycle after the acknowledge.
- R8: The page register keeps its value across any number of forwarded accesses until the host writes offset 0x800 again.
- R9: In the upper half of the window, writes to any offset other than 0x800 leave the page register unchanged, and reads of those offsets return zero.
- R10: `hostReqReady` is 0 while an internal request is outstanding or a response is being presented, and no new request is taken then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReqValid | input | 1 | Host request present |
| hostReqReady | output | 1 | Bridge can take a request |
| hostReqWrite | input | 1 | 1 = write, 0 = read |
| hostReqAddr | input | 12 | Byte offset within the window |
| hostReqWdata | input | 32 | Host write data |
| hostRspValid | output | 1 | One-cycle read response strobe |
| hostRspData | output | 32 | Read response data |
| intReqValid | output | 1 | Internal request outstanding |
| intWrite | output | 1 | Internal request direction, 1 = write |
| intAddr | output | 16 | Internal word address |
| intDevSel | output | 5 | Target device number |
| intWdata | output | 16 | Internal write data |
| intAck | input | 1 | Internal acknowledge |
| intRdata | input | 16 | Internal read data, valid with the acknowledge |

## Verification
A local read of the window answers at the first sample after the accepting edge. A forwarded request appears at that same sample. A forwarded read answers at the first sample after the edge that sees the acknowledge. A forwarded write shows the bridge ready again at that sample. The bench drives inputs and samples outputs on the falling edge. It acts as the internal responder inside each access task with a latency of zero to three cycles. Each result is checked at the exact sample these counts give, and the "not ready" and "no response" cases are checked in the waiting cycles in between.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef struct packed {
    logic loadPage;
    logic latchReq;
    logic latchRsp;
    logic rspFromLocal;
  } pwbStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } pwbState_t;

endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int DEV_W       = 5,
  parameter int PAGE_W      = 7,
  parameter int WORD_W      = 9,
  parameter int INT_DATA_W  = 16,
  parameter int HOST_DATA_W = 32,
  localparam int WIN_ADDR_W = WORD_W + 3,
  localparam int INT_ADDR_W = PAGE_W + WORD_W,
  localparam int PAGE_REG_W = DEV_W + PAGE_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pwbStrobes_t            strobes,
  input  logic                   hostReqWrite,
  input  logic [WIN_ADDR_W-1:0]  hostReqAddr,
  input  logic [HOST_DATA_W-1:0] hostReqWdata,
  input  logic [INT_DATA_W-1:0]  intRdata,
  output logic                   isWindow,
  output logic                   reqIsWrite,
  output logic [INT_ADDR_W-1:0]  intAddr,
  output logic [DEV_W-1:0]       intDevSel,
  output logic [INT_DATA_W-1:0]  intWdata,
  output logic [HOST_DATA_W-1:0] hostRspData
);

  localparam logic [WIN_ADDR_W-1:0] PAGE_OFFSET = WIN_ADDR_W'(1) << (WIN_ADDR_W - 1);

  logic [PAGE_REG_W-1:0]  pageReg;
  logic [WORD_W-1:0]      wordQ;
  logic                   writeQ;
  logic [INT_DATA_W-1:0]  wdataQ;
  logic [HOST_DATA_W-1:0] rspQ;
  logic                   isPageReg;
  logic [HOST_DATA_W-1:0] localRd;
  logic                   unusedHostBits;

  // decode of the window offset
  assign isWindow  = ~hostReqAddr[WIN_ADDR_W-1];
  assign isPageReg = (hostReqAddr == PAGE_OFFSET);
  assign localRd   = isPageReg ? HOST_DATA_W'(pageReg) : '0;

  assign unusedHostBits = ^hostReqWdata[HOST_DATA_W-1:INT_DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      wordQ   <= '0;
      writeQ  <= 1'b0;
      wdataQ  <= '0;
      rspQ    <= '0;
    end else begin
      if (strobes.loadPage && isPageReg) begin
        pageReg <= hostReqWdata[PAGE_REG_W-1:0];
      end
      if (strobes.latchReq) begin
        wordQ  <= hostReqAddr[WORD_W+1:2];
        writeQ <= hostReqWrite;
        wdataQ <= hostReqWdata[INT_DATA_W-1:0];
      end
      if (strobes.latchRsp) begin
        rspQ <= strobes.rspFromLocal ? localRd : HOST_DATA_W'(intRdata);
      end
    end
  end

  // address composition: page field on top, word offset below
  assign intAddr     = {pageReg[PAGE_W-1:0], wordQ};
  assign intDevSel   = pageReg[PAGE_REG_W-1:PAGE_W];
  assign intWdata    = wdataQ;
  assign reqIsWrite  = writeQ;
  assign hostRspData = rspQ;

endmodule

// File: rtl/pwb_control.sv
module pwb_control
  import pwb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReqValid,
  input  logic        hostReqWrite,
  input  logic        isWindow,
  input  logic        reqIsWrite,
  input  logic        intAck,
  output pwbStrobes_t strobes,
  output logic        hostReqReady,
  output logic        intReqValid,
  output logic        hostRspValid
);

  pwbState_t state;
  pwbState_t stateNext;
  logic      accept;

  assign accept = hostReqValid && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (isWindow) begin
            strobes.latchReq = 1'b1;
            stateNext        = ST_BUSY;
          end else if (hostReqWrite) begin
            strobes.loadPage = 1'b1;
          end else begin
            strobes.latchRsp     = 1'b1;
            strobes.rspFromLocal = 1'b1;
            stateNext            = ST_RESP;
          end
        end
      end
      ST_BUSY: begin
        if (intAck) begin
          if (reqIsWrite) begin
            stateNext = ST_IDLE;
          end else begin
            strobes.latchRsp = 1'b1;
            stateNext        = ST_RESP;
          end
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hostReqReady = (state == ST_IDLE);
  assign intReqValid  = (state == ST_BUSY);
  assign hostRspValid = (state == ST_RESP);

endmodule

// File: rtl/paged_window_bridge.sv
module paged_window_bridge
  import pwb_pkg::*;
#(
  parameter int DEV_W       = 5,
  parameter int PAGE_W      = 7,
  parameter int WORD_W      = 9,
  parameter int INT_DATA_W  = 16,
  parameter int HOST_DATA_W = 32,
  localparam int WIN_ADDR_W = WORD_W + 3,
  localparam int INT_ADDR_W = PAGE_W + WORD_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostReqValid,
  output logic                   hostReqReady,
  input  logic                   hostReqWrite,
  input  logic [WIN_ADDR_W-1:0]  hostReqAddr,
  input  logic [HOST_DATA_W-1:0] hostReqWdata,
  output logic                   hostRspValid,
  output logic [HOST_DATA_W-1:0] hostRspData,
  output logic                   intReqValid,
  output logic                   intWrite,
  output logic [INT_ADDR_W-1:0]  intAddr,
  output logic [DEV_W-1:0]       intDevSel,
  output logic [INT_DATA_W-1:0]  intWdata,
  input  logic                   intAck,
  input  logic [INT_DATA_W-1:0]  intRdata
);

  pwbStrobes_t strobes;
  logic        isWindow;
  logic        reqIsWrite;

  pwb_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .hostReqValid (hostReqValid),
    .hostReqWrite (hostReqWrite),
    .isWindow     (isWindow),
    .reqIsWrite   (reqIsWrite),
    .intAck       (intAck),
    .strobes      (strobes),
    .hostReqReady (hostReqReady),
    .intReqValid  (intReqValid),
    .hostRspValid (hostRspValid)
  );

  pwb_datapath #(
    .DEV_W       (DEV_W),
    .PAGE_W      (PAGE_W),
    .WORD_W      (WORD_W),
    .INT_DATA_W  (INT_DATA_W),
    .HOST_DATA_W (HOST_DATA_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .hostReqWrite (hostReqWrite),
    .hostReqAddr  (hostReqAddr),
    .hostReqWdata (hostReqWdata),
    .intRdata     (intRdata),
    .isWindow     (isWindow),
    .reqIsWrite   (reqIsWrite),
    .intAddr      (intAddr),
    .intDevSel    (intDevSel),
    .intWdata     (intWdata),
    .hostRspData  (hostRspData)
  );

  assign intWrite = reqIsWrite;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int DEV_W       = 5,
  parameter int PAGE_W      = 7,
  parameter int WORD_W      = 9,
  parameter int INT_DATA_W  = 16,
  localparam int WIN_ADDR_W = WORD_W + 3,
  localparam int INT_ADDR_W = PAGE_W + WORD_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  hostReqValid,
  input logic                  hostReqReady,
  input logic                  hostReqWrite,
  input logic [WIN_ADDR_W-1:0] hostReqAddr,
  input logic [DEV_W-1:0]      pageDevIn,
  input logic                  hostRspValid,
  input logic                  intReqValid,
  input logic                  intWrite,
  input logic [INT_ADDR_W-1:0] intAddr,
  input logic [DEV_W-1:0]      intDevSel,
  input logic [INT_DATA_W-1:0] intWdata,
  input logic                  intAck
);

  localparam logic [WIN_ADDR_W-1:0] PAGE_OFFSET = WIN_ADDR_W'(1) << (WIN_ADDR_W - 1);

  logic acceptNow;
  assign acceptNow = hostReqValid && hostReqReady;

  a_r2_page_load: assert property (@(posedge clk) disable iff (!rstN)
    acceptNow && hostReqWrite && (hostReqAddr == PAGE_OFFSET) |=> intDevSel == $past(pageDevIn));

  a_r3_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    hostRspValid |=> !hostRspValid);

  a_r5_issue_next: assert property (@(posedge clk) disable iff (!rstN)
    acceptNow && !hostReqAddr[WIN_ADDR_W-1] |=> intReqValid);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rstN)
    intReqValid && !intAck |=> intReqValid && $stable(intAddr) && $stable(intDevSel)
                               && $stable(intWrite) && $stable(intWdata));

  a_r6_read_rsp: assert property (@(posedge clk) disable iff (!rstN)
    intReqValid && intAck && !intWrite |=> hostRspValid);

  a_r7_write_done: assert property (@(posedge clk) disable iff (!rstN)
    intReqValid && intAck && intWrite |=> !hostRspValid && hostReqReady);

  a_r9_other_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    acceptNow && hostReqWrite && hostReqAddr[WIN_ADDR_W-1] && (hostReqAddr != PAGE_OFFSET)
      |=> $stable(intDevSel));

  a_r10_ready_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    hostReqReady |-> !intReqValid && !hostRspValid);

endmodule

bind paged_window_bridge pwb_checker #(
  .DEV_W      (DEV_W),
  .PAGE_W     (PAGE_W),
  .WORD_W     (WORD_W),
  .INT_DATA_W (INT_DATA_W)
) u_pwb_checker (
  .clk          (clk),
  .rstN         (rstN),
  .hostReqValid (hostReqValid),
  .hostReqReady (hostReqReady),
  .hostReqWrite (hostReqWrite),
  .hostReqAddr  (hostReqAddr),
  .pageDevIn    (hostReqWdata[DEV_W+PAGE_W-1:PAGE_W]),
  .hostRspValid (hostRspValid),
  .intReqValid  (intReqValid),
  .intWrite     (intWrite),
  .intAddr      (intAddr),
  .intDevSel    (intDevSel),
  .intWdata     (intWdata),
  .intAck       (intAck)
);

// File: tb/paged_window_bridge_bench.sv
module paged_window_bridge_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReqValid = 1'b0;
  logic        hostReqReady;
  logic        hostReqWrite = 1'b0;
  logic [11:0] hostReqAddr = '0;
  logic [31:0] hostReqWdata = '0;
  logic        hostRspValid;
  logic [31:0] hostRspData;
  logic        intReqValid;
  logic        intWrite;
  logic [15:0] intAddr;
  logic [4:0]  intDevSel;
  logic [15:0] intWdata;
  logic        intAck = 1'b0;
  logic [15:0] intRdata = '0;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  paged_window_bridge u_paged_window_bridge (
    .clk(clk), .rstN(rstN),
    .hostReqValid(hostReqValid), .hostReqReady(hostReqReady),
    .hostReqWrite(hostReqWrite), .hostReqAddr(hostReqAddr), .hostReqWdata(hostReqWdata),
    .hostRspValid(hostRspValid), .hostRspData(hostRspData),
    .intReqValid(intReqValid), .intWrite(intWrite), .intAddr(intAddr),
    .intDevSel(intDevSel), .intWdata(intWdata),
    .intAck(intAck), .intRdata(intRdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [4:0] dev, input logic [15:0] a);
    return a ^ {dev, 11'h2A5};
  endfunction

  // page write at offset 0x800 (R2)
  task automatic pageWrite(input logic [31:0] wd);
    chk(hostReqReady, "R10 ready before page write", {31'b0, hostReqReady}, 32'd1);
    hostReqValid = 1'b1; hostReqWrite = 1'b1; hostReqAddr = 12'h800; hostReqWdata = wd;
    @(negedge clk);
    hostReqValid = 1'b0;
    chk(intDevSel == wd[11:7], "R2 device select after page write", {27'b0, intDevSel}, {27'b0, wd[11:7]});
    chk(!hostRspValid && !intReqValid, "R2 page write has no response", {31'b0, hostRspValid}, 32'd0);
  endtask

  // write to an upper-half offset other than 0x800 (R9)
  task automatic otherWrite(input logic [11:0] a, input logic [31:0] wd);
    hostReqValid = 1'b1; hostReqWrite = 1'b1; hostReqAddr = a; hostReqWdata = wd;
    @(negedge clk);
    hostReqValid = 1'b0;
    chk(!hostRspValid && !intReqValid && hostReqReady, "R9 other write no activity",
        {31'b0, intReqValid}, 32'd0);
  endtask

  // read of the upper half, answered locally (R3, R9)
  task automatic localRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    hostReqValid = 1'b1; hostReqWrite = 1'b0; hostReqAddr = a;
    @(negedge clk);
    hostReqValid = 1'b0;
    chk(hostRspValid, {tag, " response strobe"}, {31'b0, hostRspValid}, 32'd1);
    chk(hostRspData == exp, {tag, " response data"}, hostRspData, exp);
    chk(!hostReqReady, "R10 not ready while responding", {31'b0, hostReqReady}, 32'd0);
    @(negedge clk);
    chk(!hostRspValid && hostReqReady, "R3 response lasts one cycle", {31'b0, hostRspValid}, 32'd0);
  endtask

  // forwarded access with the bench acting as internal responder (R4..R7, R10)
  task automatic winAccess(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                           input int lat, input logic [4:0] dev, input logic [6:0] pg);
    logic [15:0] expAddr;
    logic [15:0] rd;
    expAddr = {pg, a[10:2]};
    rd = model(dev, expAddr);
    hostReqValid = 1'b1; hostReqWrite = wr; hostReqAddr = a; hostReqWdata = wd;
    @(negedge clk);
    hostReqValid = 1'b0;
    chk(intReqValid, "R5 request issued next cycle", {31'b0, intReqValid}, 32'd1);
    chk(intAddr == expAddr, "R4 internal address", {16'b0, intAddr}, {16'b0, expAddr});
    chk(intDevSel == dev, "R4 device select", {27'b0, intDevSel}, {27'b0, dev});
    chk(intWrite == wr, "R5 direction", {31'b0, intWrite}, {31'b0, wr});
    if (wr) chk(intWdata == wd[15:0], "R5 write data", {16'b0, intWdata}, {16'b0, wd[15:0]});
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(intReqValid && intAddr == expAddr, "R5 request held", {16'b0, intAddr}, {16'b0, expAddr});
      chk(!hostReqReady && !hostRspValid, "R10 busy while waiting", {31'b0, hostReqReady}, 32'd0);
    end
    intAck = 1'b1; intRdata = rd;
    @(negedge clk);
    intAck = 1'b0; intRdata = 16'hFFFF;
    if (wr) begin
      chk(hostReqReady && !hostRspValid && !intReqValid, "R7 write completes silently",
          {30'b0, hostRspValid, hostReqReady}, 32'd1);
    end else begin
      chk(hostRspValid, "R6 read response strobe", {31'b0, hostRspValid}, 32'd1);
      chk(hostRspData == {16'b0, rd}, "R6 read data zero-extended", hostRspData, {16'b0, rd});
      @(negedge clk);
      chk(!hostRspValid && hostReqReady, "R6 response single cycle", {31'b0, hostRspValid}, 32'd0);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hostReqReady, "R1 ready after reset", {31'b0, hostReqReady}, 32'd1);
    chk(!hostRspValid && !intReqValid, "R1 idle outputs", {30'b0, hostRspValid, intReqValid}, 32'd0);
    chk(intDevSel == 5'd0, "R1 device select zero", {27'b0, intDevSel}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    localRead(12'h800, 32'd0, "R1 page reset value");

    // R2/R3: every device and page, with noise in the ignored upper bits
    for (int d = 0; d < 32; d++) begin
      for (int p = 0; p < 128; p++) begin
        logic [31:0] wd;
        wd = {20'hA5C3F ^ 20'(d * 977 + p), 5'(d), 7'(p)};
        pageWrite(wd);
        localRead(12'h800, {20'b0, 5'(d), 7'(p)}, "R3 page readback");
      end
    end

    // R4..R7: sweep every word offset on two pages, low byte bits varied
    for (int s = 0; s < 2; s++) begin
      logic [4:0] dev;
      logic [6:0] pg;
      dev = s ? 5'd31 : 5'd6;
      pg  = s ? 7'h55 : 7'h7F;
      pageWrite({20'hFFFFF, dev, pg});
      for (int o = 0; o < 512; o++) begin
        logic [11:0] a;
        a = {1'b0, 9'(o), 2'(o)};
        winAccess(1'b0, a, 32'h0, o % 4, dev, pg);
        winAccess(1'b1, a, 32'(o * 40503 + 32'h1234_0000), (o + 1) % 4, dev, pg);
      end
      // R8: page still intact after all forwarded accesses
      localRead(12'h800, {20'b0, dev, pg}, "R8 page persists");
    end

    // R9: other upper-half offsets
    pageWrite({20'h0, 5'd9, 7'h21});
    otherWrite(12'h804, 32'hFFFF_FFFF);
    otherWrite(12'hFFC, 32'h0000_0000);
    otherWrite(12'h801, 32'h0000_0ABC);
    localRead(12'h800, {20'b0, 5'd9, 7'h21}, "R9 page unchanged by other writes");
    localRead(12'h804, 32'd0, "R9 other read zero");
    localRead(12'hA00, 32'd0, "R9 other read zero");
    localRead(12'hFFC, 32'd0, "R9 other read zero");
    winAccess(1'b0, 12'h7FF, 32'h0, 0, 5'd9, 7'h21);

    finishRun();
  end

endmodule